// File: doc/BRIEF.md
# Exception Entry Sequencing Controller

This block sits next to a simple pipelined processor and moves it from normal execution into a kernel handler when a trap is taken. There are three trap kinds. A reset request has the highest priority. Synchronous exceptions from the oldest pipeline stage come next, and each one carries a cause code, its PC and, for translation misses, the faulting virtual address. Enabled external interrupt lines come last. The controller does not give each source its own handler address. It records the identity of the trap in a cause register and sends fetch to one of three targets: a reset target, a target for translation misses taken in user mode, and one shared target for everything else.

On entry the block flushes the pipeline and cancels pending write-back in the first cycle. It redirects fetch in the second cycle. In the acceptance cycle it saves the trap PC, records the cause, and pushes the mode and interrupt-enable bits onto a two-level status stack. A return-from-exception pulse pops that stack. A plain status write port lets privileged code set the four status bits.

Synchronous requests use a valid/ready stream. `xreq_ready` is high only when the controller is idle and no reset request is present. A request that is not accepted must hold `xreq_valid` and its payload steady until it is accepted. Every other pin is a plain level or strobe.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After `rst_n` is released the block is idle: `busy`, `flush` and `redirect_valid` are 0, `xreq_ready` is 1, and all four status bits are 0. Kernel mode is user bit = 0, and interrupts off is ie bit = 0.
- R2: When requests arrive in the same idle cycle, `rst_req` wins over `xreq_valid`, and `xreq_valid` wins over interrupts. `xreq_ready` is 0 while `rst_req` is high. A reset entry redirects to `RESET_VEC`, clears all four status bits, and leaves EPC and cause unchanged.
- R3: An accepted entry raises `busy` for exactly two cycles. `flush` is high in the first of them and `redirect_valid` is high in the second. `redirect_valid` lasts exactly one cycle.
- R4: On a non-reset entry the previous user/ie bits take the current values, and the current user/ie bits become 0. The result is visible in the first busy cycle.
- R5: `epc` takes `xreq_pc` for a synchronous entry and `commit_pc` for an interrupt entry.
- R6: `cause_code` takes 0 for an interrupt entry and `xreq_code` for a synchronous entry. On every non-reset entry, `cause_ip` takes a snapshot of `irq_lines`. Codes: 0 interrupt, 2 translation load miss, 3 translation store miss, 8 syscall, 10 reserved instruction.
- R7: A synchronous entry with code 2 or 3 while the current user bit is 1 redirects to `UTLB_VEC`. Every other non-reset entry redirects to `GEN_VEC`.
- R8: `badvaddr` takes `xreq_vaddr` only on a synchronous entry with code 2 or 3. Otherwise it holds its value.
- R9: While the current ie bit is 0, interrupt lines start no entry.
- R10: An idle `eret` with no entry in the same cycle copies the previous user/ie bits into the current ones in one cycle and leaves the previous bits unchanged. If an entry starts in the same cycle, the entry wins and `eret` has no effect.
- R11: `xreq_ready` is 0 while `busy` is 1. A request held through that time is accepted on the first idle cycle.
- R12: An idle `st_we` with no entry and no `eret` loads the status bits from `st_wdata`: bit0 current ie, bit1 current user, bit2 previous ie, bit3 previous user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_req | input | 1 | Reset trap request, highest priority |
| xreq_valid | input | 1 | Synchronous exception request valid |
| xreq_ready | output | 1 | Request accepted this cycle when high with valid |
| xreq_code | input | 5 | Cause code of the request |
| xreq_pc | input | 32 | PC of the excepting instruction |
| xreq_vaddr | input | 32 | Faulting virtual address for translation misses |
| irq_lines | input | 8 | External interrupt lines, level sensitive |
| commit_pc | input | 32 | PC of the oldest instruction, saved for interrupts |
| eret | input | 1 | Return-from-exception strobe |
| st_we | input | 1 | Status write strobe |
| st_wdata | input | 4 | Status write data |
| busy | output | 1 | Entry in progress, stall fetch |
| flush | output | 1 | Flush pipeline and cancel pending write-back |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Handler address for the redirect |
| stat_user | output | 1 | Current mode, 1 = user |
| stat_ie | output | 1 | Current interrupt enable |
| stat_user_prev | output | 1 | Previous mode |
| stat_ie_prev | output | 1 | Previous interrupt enable |
| epc | output | 32 | Exception PC register |
| cause_code | output | 5 | Cause code field |
| cause_ip | output | 8 | Interrupt lines pending at entry |
| badvaddr | output | 32 | Bad virtual address register |

## Verification
Inputs are driven and outputs sampled on falling edges. A request driven before a rising edge is accepted at that edge. Because of this, the saved PC, cause, bad address, the status push and `flush` are all checked one sample after the request was driven. The redirect strobe and its address are checked at the next sample, and the return of `busy` to 0 one sample after that. An `eret` or status write is checked one sample after it is driven. The masked-interrupt case holds the lines for several samples and checks `busy` at each of them.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 5;
  localparam int IRQ_W  = 8;
  localparam int ADDR_W = 32;

  localparam logic [CODE_W-1:0] C_INT  = 5'd0;
  localparam logic [CODE_W-1:0] C_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] C_TLBS = 5'd3;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_RESET = 2'd1,
    K_SYNC  = 2'd2,
    K_IRQ   = 2'd3
  } trap_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ENT1 = 2'd1,
    S_ENT2 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
#(
  parameter int N_IRQ = IRQ_W
) (
  input  logic             idle,
  input  logic             rst_req,
  input  logic             xreq_valid,
  input  logic             cur_ie,
  input  logic [N_IRQ-1:0] irq_lines,
  output trap_kind_e       kind,
  output logic             xreq_ready
);
  always_comb begin
    kind = K_NONE;
    if (idle) begin
      if (rst_req)                    kind = K_RESET;
      else if (xreq_valid)            kind = K_SYNC;
      else if (cur_ie && |irq_lines)  kind = K_IRQ;
    end
  end

  assign xreq_ready = idle && !rst_req;
endmodule

// File: rtl/exc_status.sv
module exc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       clear,
  input  logic       pop,
  input  logic       we,
  input  logic [3:0] wdata,
  output logic       user_cur,
  output logic       ie_cur,
  output logic       user_prev,
  output logic       ie_prev
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_cur  <= 1'b0;
      ie_cur    <= 1'b0;
      user_prev <= 1'b0;
      ie_prev   <= 1'b0;
    end else if (clear) begin
      user_cur  <= 1'b0;
      ie_cur    <= 1'b0;
      user_prev <= 1'b0;
      ie_prev   <= 1'b0;
    end else if (push) begin
      user_prev <= user_cur;
      ie_prev   <= ie_cur;
      user_cur  <= 1'b0;
      ie_cur    <= 1'b0;
    end else if (pop) begin
      user_cur  <= user_prev;
      ie_cur    <= ie_prev;
    end else if (we) begin
      ie_cur    <= wdata[0];
      user_cur  <= wdata[1];
      ie_prev   <= wdata[2];
      user_prev <= wdata[3];
    end
  end

  // R10: a pop restores current bits from previous ones and keeps previous
  assert_pop_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clear) |=> (user_cur == $past(user_prev) && ie_cur == $past(ie_prev)
                                  && $stable(user_prev) && $stable(ie_prev)));

  // R4: a push moves current into previous
  assert_push_saves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |=> (user_prev == $past(user_cur) && ie_prev == $past(ie_cur)));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic busy,
  output logic flush,
  output logic redirect
);
  seq_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else begin
      unique case (st_q)
        S_IDLE:  if (start) st_q <= S_ENT1;
        S_ENT1:  st_q <= S_ENT2;
        S_ENT2:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idle     = (st_q == S_IDLE);
  assign busy     = !idle;
  assign flush    = (st_q == S_ENT1);
  assign redirect = (st_q == S_ENT2);

  // R3: flush is followed by the redirect strobe in the next cycle
  assert_flush_then_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> redirect);

  // R3: redirect strobe lasts one cycle and ends the busy window
  assert_redirect_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!redirect && !busy));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] UTLB_VEC  = 32'h8000_0000,
  parameter logic [31:0] GEN_VEC   = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_req,
  input  logic        xreq_valid,
  output logic        xreq_ready,
  input  logic [4:0]  xreq_code,
  input  logic [31:0] xreq_pc,
  input  logic [31:0] xreq_vaddr,
  input  logic [7:0]  irq_lines,
  input  logic [31:0] commit_pc,
  input  logic        eret,
  input  logic        st_we,
  input  logic [3:0]  st_wdata,
  output logic        busy,
  output logic        flush,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic        stat_user,
  output logic        stat_ie,
  output logic        stat_user_prev,
  output logic        stat_ie_prev,
  output logic [31:0] epc,
  output logic [4:0]  cause_code,
  output logic [7:0]  cause_ip,
  output logic [31:0] badvaddr
);
  trap_kind_e kind;
  logic idle, start, is_reset, is_sync, is_irq, is_tlb;
  logic eret_ok, we_ok;
  logic [31:0] vec_d, vec_q;

  exc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
    .busy(busy), .flush(flush), .redirect(redirect_valid)
  );

  exc_arb #(.N_IRQ(IRQ_W)) u_arb (
    .idle(idle), .rst_req(rst_req), .xreq_valid(xreq_valid),
    .cur_ie(stat_ie), .irq_lines(irq_lines), .kind(kind), .xreq_ready(xreq_ready)
  );

  assign start    = (kind != K_NONE);
  assign is_reset = (kind == K_RESET);
  assign is_sync  = (kind == K_SYNC);
  assign is_irq   = (kind == K_IRQ);
  assign is_tlb   = (xreq_code == C_TLBL) || (xreq_code == C_TLBS);
  assign eret_ok  = idle && !start && eret;
  assign we_ok    = idle && !start && !eret && st_we;

  exc_status u_status (
    .clk(clk), .rst_n(rst_n),
    .push(start && !is_reset), .clear(is_reset), .pop(eret_ok),
    .we(we_ok), .wdata(st_wdata),
    .user_cur(stat_user), .ie_cur(stat_ie),
    .user_prev(stat_user_prev), .ie_prev(stat_ie_prev)
  );

  always_comb begin
    if (is_reset)                       vec_d = RESET_VEC;
    else if (is_sync && is_tlb && stat_user) vec_d = UTLB_VEC;
    else                                vec_d = GEN_VEC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= RESET_VEC;
      epc        <= '0;
      cause_code <= '0;
      cause_ip   <= '0;
      badvaddr   <= '0;
    end else if (start) begin
      vec_q <= vec_d;
      if (!is_reset) begin
        epc        <= is_irq ? commit_pc : xreq_pc;
        cause_code <= is_irq ? C_INT : xreq_code;
        cause_ip   <= irq_lines;
      end
      if (is_sync && is_tlb) badvaddr <= xreq_vaddr;
    end
  end

  assign redirect_pc = vec_q;

  // R4: entering a handler leaves the core in kernel mode with interrupts off
  assert_entry_kernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!stat_user && !stat_ie));

  // R11: no request is accepted while an entry is in progress
  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !xreq_ready);

  // R9: with interrupts disabled and no other request, nothing starts
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !stat_ie && !xreq_valid && !rst_req) |=> !busy);

  // R8: bad address register changes only at the start of an entry
  assert_badva_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(badvaddr));
endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
  localparam logic [31:0] RV = 32'hBFC0_0000;
  localparam logic [31:0] UV = 32'h8000_0000;
  localparam logic [31:0] GV = 32'h8000_0080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 0, xreq_valid = 0, eret = 0, st_we = 0;
  logic [4:0] xreq_code = 0;
  logic [31:0] xreq_pc = 0, xreq_vaddr = 0, commit_pc = 0;
  logic [7:0] irq_lines = 0;
  logic [3:0] st_wdata = 0;
  logic xreq_ready, busy, flush, redirect_valid;
  logic [31:0] redirect_pc, epc, badvaddr;
  logic stat_user, stat_ie, stat_user_prev, stat_ie_prev;
  logic [4:0] cause_code;
  logic [7:0] cause_ip;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] st();
    return {stat_user_prev, stat_ie_prev, stat_user, stat_ie};
  endfunction

  // request already driven at the current negedge; walks the two-cycle entry
  task automatic walk_entry(input logic [31:0] vec, input string tag);
    @(negedge clk);
    xreq_valid = 0; rst_req = 0; irq_lines = 0; eret = 0;
    chk({tag, " R3 busy1"}, busy, 1);
    chk({tag, " R3 flush"}, flush, 1);
    chk({tag, " R3 nored1"}, redirect_valid, 0);
    chk({tag, " R11 ready low"}, xreq_ready, 0);
    @(negedge clk);
    chk({tag, " R3 busy2"}, busy, 1);
    chk({tag, " R3 flush2"}, flush, 0);
    chk({tag, " R3 redirect"}, redirect_valid, 1);
    chk({tag, " R7 vector"}, redirect_pc, vec);
    @(negedge clk);
    chk({tag, " R3 done"}, busy, 0);
    chk({tag, " R3 strobe one"}, redirect_valid, 0);
  endtask

  task automatic write_status(input logic [3:0] v);
    st_we = 1; st_wdata = v;
    @(negedge clk);
    st_we = 0;
    chk("R12 status write", st(), v);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 flush", flush, 0);
    chk("R1 redirect", redirect_valid, 0);
    chk("R1 ready", xreq_ready, 1);
    chk("R1 status", st(), 4'b0000);
  endtask

  task automatic t_syscall();
    xreq_valid = 1; xreq_code = 5'd8; xreq_pc = 32'h0000_1000; xreq_vaddr = 32'h1111_1111;
    irq_lines = 8'h01;
    walk_entry(GV, "syscall");
    chk("R5 epc sync", epc, 32'h0000_1000);
    chk("R6 cause sync", cause_code, 8);
    chk("R6 ip snapshot", cause_ip, 8'h01);
    chk("R8 badva untouched", badvaddr, 0);
  endtask

  task automatic t_irq_masked();
    write_status(4'b0010);
    irq_lines = 8'h04;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 masked no busy", busy, 0);
    end
    irq_lines = 0;
    chk("R9 cause kept", cause_code, 8);
  endtask

  task automatic t_irq_taken();
    write_status(4'b0011);
    irq_lines = 8'h24; commit_pc = 32'h0000_2000;
    walk_entry(GV, "irq");
    chk("R5 epc irq", epc, 32'h0000_2000);
    chk("R6 cause irq", cause_code, 0);
    chk("R6 ip irq", cause_ip, 8'h24);
    chk("R4 push", st(), 4'b1100);
  endtask

  task automatic t_eret();
    eret = 1;
    @(negedge clk);
    eret = 0;
    chk("R10 pop", st(), 4'b1111);
  endtask

  task automatic t_utlb();
    xreq_valid = 1; xreq_code = 5'd2; xreq_pc = 32'h0040_0010; xreq_vaddr = 32'hDEAD_0000;
    walk_entry(UV, "utlb");
    chk("R8 badva utlb", badvaddr, 32'hDEAD_0000);
    chk("R6 cause tlbl", cause_code, 2);
    chk("R4 push user", st(), 4'b1100);
  endtask

  task automatic t_ktlb();
    xreq_valid = 1; xreq_code = 5'd3; xreq_pc = 32'h8000_1234; xreq_vaddr = 32'hCAFE_0004;
    walk_entry(GV, "ktlb R7");
    chk("R8 badva ktlb", badvaddr, 32'hCAFE_0004);
    chk("R6 cause tlbs", cause_code, 3);
    chk("R4 push kernel", st(), 4'b0000);
  endtask

  task automatic t_ri_keeps_badva();
    write_status(4'b0010);
    xreq_valid = 1; xreq_code = 5'd10; xreq_pc = 32'h0040_0100; xreq_vaddr = 32'h5555_5555;
    walk_entry(GV, "ri");
    chk("R8 badva held", badvaddr, 32'hCAFE_0004);
    chk("R6 cause ri", cause_code, 10);
  endtask

  task automatic t_priority();
    write_status(4'b0011);
    rst_req = 1; xreq_valid = 1; xreq_code = 5'd8; xreq_pc = 32'h0000_3000; irq_lines = 8'h80;
    #1;
    chk("R2 ready low on reset", xreq_ready, 0);
    @(negedge clk);
    rst_req = 0; irq_lines = 0;
    chk("R2 reset status", st(), 4'b0000);
    chk("R2 epc kept", epc, 32'h0040_0100);
    chk("R11 ready busy", xreq_ready, 0);
    @(negedge clk);
    chk("R2 reset vector", redirect_pc, RV);
    chk("R2 redirect", redirect_valid, 1);
    @(negedge clk);
    chk("R11 held taken", busy, 0);
    walk_entry(GV, "held R11");
    chk("R11 held epc", epc, 32'h0000_3000);
    write_status(4'b0011);
    xreq_valid = 1; xreq_code = 5'd10; xreq_pc = 32'h0000_4000; irq_lines = 8'h02;
    eret = 1;
    walk_entry(GV, "sync over irq");
    chk("R2 sync beats irq", cause_code, 10);
    chk("R10 eret lost to entry", st(), 4'b1100);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_syscall();
    t_irq_masked();
    t_irq_taken();
    t_eret();
    t_utlb();
    t_ktlb();
    t_ri_keeps_badva();
    t_priority();
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule